// File: doc/BRIEF.md
# Four-Way Branching Microcode Sequencer

This block is a table-driven controller. A 4-bit state register picks a pair of condition inputs. Those two bits choose one of exactly four successors for the current state. A constant word table supplies the successor and a 14-bit control vector. The successor and the control vector are loaded on the same rising edge.

A parameter selects one of two table organisations. In the deep organisation, the state itself chooses which condition pair is read. The state and the two branch bits then address a 64-entry table of 18-bit words. In the wide organisation, the table has one 32-bit word per state, so it is 16 words deep. Each word holds a 2-bit encoded pair select, all four candidate successors and one control vector for the state. The branch bits choose which candidate is loaded. The table contents are computed at elaboration from fixed formulas, which stand in for a real microprogram.

Top module: `branch_seq_rom`

## Requirements
- R1: While the reset input is low, the state output and the control output are both zero, and a falling reset input clears them without waiting for a clock edge.
- R2: After the reset input rises, the state holds 0 through the next two rising edges. The first load from the table happens on the third rising edge.
- R3: In the deep organisation (HORIZONTAL=0) the pair index p equals state[1:0]. The branch value is b = 2*cond[2p+1] + cond[2p].
- R4: In the deep organisation, each rising edge out of reset loads the state s' = (5*s + 3*b + 1) mod 16.
- R5: In the deep organisation, the control output loaded with that state is {s[3:0], b[1:0], s^4'b1010, (s+b) mod 16}, most significant field first. Here s is the state before the edge.
- R6: In the wide organisation (HORIZONTAL=1) the pair index comes from the word's encoded select field, which equals s[3:2] XOR s[1:0]. The branch value b is formed from cond as in R3.
- R7: In the wide organisation, the loaded state is the stored candidate selected by b, which equals (5*s + 3*b + 1) mod 16.
- R8: In the wide organisation, the control output loaded is {s, 2'b11, s^4'b1010, ~s} for every branch value.
- R9: Condition inputs outside the selected pair have no effect on the loaded state or control output.
- R10: State and control outputs change only at rising clock edges. Condition changes between edges leave them untouched until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cond_i | input | 8 | Condition inputs, four pairs of two bits |
| ctrl_o | output | 14 | Registered control vector |
| state_o | output | 4 | Current state register |

## Verification
The hardest case to reach is reaching every state with each of the four branch values while the unselected condition bits carry misleading values. The state sequence depends on the path taken, so a fixed input pattern visits only a few states. The stimulus runs long stretches of full random condition vectors on both organisations in parallel, which drives each state machine through most of its state space. It adds walking-one vectors and mid-cycle condition flips that are undone before the edge. A reset in the middle of the run then checks the clear and the two-edge release delay from a non-zero state.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int ST_W   = 4;
  localparam int CT_W   = 14;
  localparam int BR_W   = 2;
  localparam int PAIR_W = 2;
  localparam int NWAY   = 1 << BR_W;
  localparam int NCOND  = (1 << PAIR_W) * BR_W;

  // successor formula shared by both table organisations
  function automatic logic [ST_W-1:0] succ_f(input logic [ST_W-1:0] s,
                                             input logic [BR_W-1:0] b);
    logic [31:0] t;
    t = 32'(5 * int'(s) + 3 * int'(b) + 1);
    return t[ST_W-1:0];
  endfunction

  // control vector of the deep organisation, one per (state, branch)
  function automatic logic [CT_W-1:0] ctrl_v_f(input logic [ST_W-1:0] s,
                                               input logic [BR_W-1:0] b);
    logic [ST_W-1:0] sum;
    sum = s + {{(ST_W-BR_W){1'b0}}, b};
    return {s, b, s ^ 4'b1010, sum};
  endfunction

  // control vector of the wide organisation, one per state
  function automatic logic [CT_W-1:0] ctrl_h_f(input logic [ST_W-1:0] s);
    return {s, 2'b11, s ^ 4'b1010, ~s};
  endfunction

  // encoded condition pair select stored in the wide word
  function automatic logic [PAIR_W-1:0] sel_h_f(input logic [ST_W-1:0] s);
    return s[3:2] ^ s[1:0];
  endfunction
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

  // R2: release reaches the core only after the input was high two edges back
  p_release_delay_r2: assert property (@(posedge clk_i)
    $rose(rst_no) |-> $past(rst_ni, 2));
endmodule

// File: rtl/bseq_cond_mux.sv
module bseq_cond_mux #(
  parameter int PAIR_W = 2,
  parameter int BR_W   = 2,
  localparam int NPAIR = 1 << PAIR_W,
  localparam int NCOND = NPAIR * BR_W
) (
  input  logic [NCOND-1:0]  cond_i,
  input  logic [PAIR_W-1:0] pair_i,
  output logic [BR_W-1:0]   branch_o
);
  logic [BR_W-1:0] pairs [NPAIR];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pairs[p] = cond_i[p*BR_W +: BR_W];
  end

  assign branch_o = pairs[pair_i];
endmodule

// File: rtl/bseq_rom.sv
module bseq_rom
  import bseq_pkg::*;
#(
  parameter bit HORIZONTAL = 1'b0,
  localparam int ADDR_W = HORIZONTAL ? ST_W : ST_W + BR_W,
  localparam int WORD_W = HORIZONTAL ? CT_W + PAIR_W + NWAY*ST_W : CT_W + ST_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] table_w [DEPTH];

  function automatic logic [WORD_W-1:0] wide_word_f(input logic [ST_W-1:0] s);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < NWAY; k++) begin
      w[k*ST_W +: ST_W] = succ_f(s, BR_W'(k));
    end
    w[NWAY*ST_W +: PAIR_W] = sel_h_f(s);
    w[WORD_W-1 -: CT_W]    = ctrl_h_f(s);
    return w;
  endfunction

  if (!HORIZONTAL) begin : g_deep
    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
      localparam logic [ST_W-1:0] S = ST_W'(a >> BR_W);
      localparam logic [BR_W-1:0] B = BR_W'(a);
      assign table_w[a] = {ctrl_v_f(S, B), succ_f(S, B)};
    end
  end else begin : g_wide
    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
      assign table_w[a] = wide_word_f(ST_W'(a));
    end
  end

  assign word_o = table_w[addr_i];
endmodule

// File: rtl/branch_seq_rom.sv
module branch_seq_rom
  import bseq_pkg::*;
#(
  parameter bit HORIZONTAL = 1'b0,
  localparam int ADDR_W = HORIZONTAL ? ST_W : ST_W + BR_W,
  localparam int WORD_W = HORIZONTAL ? CT_W + PAIR_W + NWAY*ST_W : CT_W + ST_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCOND-1:0] cond_i,
  output logic [CT_W-1:0]  ctrl_o,
  output logic [ST_W-1:0]  state_o
);
  logic              rst_sync_n;
  logic [ST_W-1:0]   state_q, state_d;
  logic [CT_W-1:0]   ctrl_q, ctrl_d;
  logic [PAIR_W-1:0] pair;
  logic [BR_W-1:0]   branch;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] word;
  logic              armed_q;

  bseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  bseq_cond_mux #(.PAIR_W(PAIR_W), .BR_W(BR_W)) u_cond_mux (
    .cond_i  (cond_i),
    .pair_i  (pair),
    .branch_o(branch)
  );

  bseq_rom #(.HORIZONTAL(HORIZONTAL)) u_rom (
    .addr_i(addr),
    .word_o(word)
  );

  if (!HORIZONTAL) begin : g_deep
    // state steers the condition pair; branch bits extend the address
    assign pair    = state_q[PAIR_W-1:0];
    assign addr    = {state_q, branch};
    assign state_d = word[ST_W-1:0];
    assign ctrl_d  = word[WORD_W-1 -: CT_W];
  end else begin : g_wide
    logic [ST_W-1:0] cand [NWAY];
    for (genvar k = 0; k < NWAY; k++) begin : g_cand
      assign cand[k] = word[k*ST_W +: ST_W];
    end
    assign addr    = state_q;
    assign pair    = word[NWAY*ST_W +: PAIR_W];
    assign state_d = cand[branch];
    assign ctrl_d  = word[WORD_W-1 -: CT_W];

    // R7: the loaded state is one of the four candidates of the previous word
    p_next_is_candidate_r7: assert property (@(posedge clk_i)
      disable iff (!rst_sync_n)
      armed_q |-> (state_q == $past(cand[0]) || state_q == $past(cand[1]) ||
                   state_q == $past(cand[2]) || state_q == $past(cand[3])));
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
      armed_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign ctrl_o  = ctrl_q;

  // R1: registers are clear whenever the internal reset is active
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_sync_n |-> (state_q == '0 && ctrl_q == '0));

  // R4: state register takes the table successor of the previous cycle
  p_state_follows_r4: assert property (@(posedge clk_i)
    disable iff (!rst_sync_n)
    armed_q |-> state_q == $past(state_d));

  // R5: control register takes the table control field of the previous cycle
  p_ctrl_follows_r5: assert property (@(posedge clk_i)
    disable iff (!rst_sync_n)
    armed_q |-> ctrl_q == $past(ctrl_d));
endmodule

// File: tb/branch_seq_rom_bench.sv
`timescale 1ns/1ps
module branch_seq_rom_bench;
  localparam time HALF = 2.5ns;
  localparam int  WATCHDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cond = '0;
  logic [13:0] ctrl_v, ctrl_h;
  logic [3:0]  st_v, st_h;

  always #HALF clk = ~clk;

  branch_seq_rom #(.HORIZONTAL(1'b0)) u_branch_seq_rom (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .ctrl_o(ctrl_v), .state_o(st_v));
  branch_seq_rom #(.HORIZONTAL(1'b1)) u_branch_seq_rom_h (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .ctrl_o(ctrl_h), .state_o(st_h));

  typedef struct {
    logic [3:0]  sv;
    logic [13:0] cv;
    logic [3:0]  sh;
    logic [13:0] ch;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int total = 0;
  int fails = 0;
  logic [3:0]  mv = '0, mh = '0;
  logic [13:0] lcv = '0, lch = '0;

  function automatic logic [3:0] succ(input logic [3:0] s, input logic [1:0] b);
    int t;
    t = (5 * int'(s) + 3 * int'(b) + 1) % 16;
    return 4'(t);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: applies one condition vector and queues the expected results
  task automatic drive(input logic [7:0] c, input string tag, input bit glitch);
    int pv, ph;
    logic [1:0] bv, bh;
    exp_t e;
    @(negedge clk);
    if (glitch) begin
      cond = ~c;
      #1;
      chk(st_v == mv && ctrl_v == lcv, "R10 deep outputs stable mid-cycle",
          {14'd0, st_v, ctrl_v}, {14'd0, mv, lcv});
      chk(st_h == mh && ctrl_h == lch, "R10 wide outputs stable mid-cycle",
          {14'd0, st_h, ctrl_h}, {14'd0, mh, lch});
    end
    cond = c;
    pv = int'(mv[1:0]);
    bv = {c[2*pv+1], c[2*pv]};
    ph = int'(mh[3:2] ^ mh[1:0]);
    bh = {c[2*ph+1], c[2*ph]};
    e.sv  = succ(mv, bv);
    e.cv  = {mv, bv, mv ^ 4'b1010, mv + {2'b00, bv}};
    e.sh  = succ(mh, bh);
    e.ch  = {mh, 2'b11, mh ^ 4'b1010, ~mh};
    e.tag = tag;
    sbq.push_back(e);
    mv = e.sv; mh = e.sh; lcv = e.cv; lch = e.ch;
  endtask

  // monitor: compares design outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(st_v == e.sv, {"R4 deep state, phase ", e.tag}, 32'(st_v), 32'(e.sv));
        chk(ctrl_v == e.cv, {"R5 deep ctrl, phase ", e.tag}, 32'(ctrl_v), 32'(e.cv));
        chk(st_h == e.sh, {"R7 wide state, phase ", e.tag}, 32'(st_h), 32'(e.sh));
        chk(ctrl_h == e.ch, {"R8 wide ctrl, phase ", e.tag}, 32'(ctrl_h), 32'(e.ch));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(st_v == 0 && ctrl_v == 0, "R1 deep clear during reset", {14'd0, st_v, ctrl_v}, 0);
    chk(st_h == 0 && ctrl_h == 0, "R1 wide clear during reset", {14'd0, st_h, ctrl_h}, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mv = '0; mh = '0; lcv = '0; lch = '0;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      chk(st_v == 0 && st_h == 0, "R2 state held after release",
          {24'd0, st_v, st_h}, 0);
    end
  endtask

  initial begin
    #(HALF * 2 * WATCHDOG_CYC);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R3 R6: walking single condition bits expose which pair is read
    for (int i = 0; i < 8; i++) drive(8'(1 << i), "R3", 1'b0);
    for (int i = 0; i < 8; i++) drive(~8'(1 << i), "R6", 1'b0);
    drive(8'hAA, "R6", 1'b0);
    drive(8'h55, "R6", 1'b0);
    drive(8'hFF, "R3", 1'b0);
    drive(8'h00, "R3", 1'b0);
    // R9: full random vectors, unselected bits carry arbitrary values
    for (int i = 0; i < 300; i++) drive(8'($urandom), "R9", 1'b0);
    // R10: conditions flipped between edges and restored before the edge
    for (int i = 0; i < 40; i++) drive(8'($urandom), "R10", 1'b1);
    // R1 R2: reset from a running, non-zero state
    @(posedge clk);
    #1;
    do_reset();
    for (int i = 0; i < 100; i++) drive(8'($urandom), "R9", 1'b0);
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule